// File: doc/BRIEF.md
# Block-Mode DMA Transfer Channel

This block is one DMA channel that moves data in blocks. Software programs a source address, a destination address, a block size and a block count, then turns the channel on. Each activation request from the selected peripheral line moves one whole block. Every data unit in the block is a read from the source followed by a write to the destination. The channel keeps the memory bus for the whole block and hands it back only between blocks.

The block size is kept in two halves of one register. The low half is a live counter that counts down during a block. The high half is a reload copy that refills the live counter when the block ends. A direction bit picks either the source or the destination as the block area. After every block, the block-area address goes back to the value it had when that block began, while the other address keeps moving forward. A separate block counter counts down once per block. When it runs out, the channel switches itself off and raises a done flag, which can drive an interrupt.

Top module: `blkdma_channel`

## Requirements
- R1: After reset, all six registers read 0, `irq_o` is 0, `mem_req_o` is 0 and `act_clr_o` is 0. The register offsets are: 0 source address, 1 destination address, 2 size, 3 block count, 4 control, 5 enable/status.
- R2: One accepted activation moves a whole block. Each unit is a read at the source address and then a write of the read data to the destination address. For byte transfers (control bit 0 = 0), only the low 8 bits are carried and the upper write-data bits are 0. For 16-bit transfers (bit 0 = 1), all 16 bits are carried.
- R3: The source mode is control bits [2:1] and the destination mode is bits [4:3]. Mode codes: 00 and 01 hold the address fixed, 10 increments it, 11 decrements it. The step is 1 for bytes and 2 for words.
- R4: Control bit 5 selects the block area: 0 means the source, 1 means the destination. After each block, the block-area address returns to its value at the start of that block. The other address keeps its advanced value.
- R5: The size register holds the live counter in bits [7:0] and the reload copy in bits [15:8]. After each block, the live counter is refilled from the reload copy. A live value of 0 acts as 1.
- R6: The block count (register 3) drops by one per finished block. When the last block finishes, the channel enable bit clears and the done flag sets.
- R7: Transfers start only while the channel enable bit (register 5 bit 0) and the master enable bit (bit 1) are both 1. Register 5 reads back {done, master, channel} in bits [2:0].
- R8: Control bits [9:6] pick which `act_req_i` line activates the channel. The other lines are ignored. A value of `NSRC` or above selects no line.
- R9: When a block is accepted and control bit 10 is 1, `act_clr_o` pulses for one cycle with only the selected line's bit set. When bit 10 is 0, `act_clr_o` stays 0.
- R10: `irq_o` equals the done flag ANDed with control bit 11. Any write to register 5 clears the done flag.
- R11: While both enable bits are 1, writes to registers 0 through 4 have no effect.
- R12: Once the channel has turned itself off, activation requests start no further bus accesses.
- R13: Once `mem_req_o` is raised, it stays high with a stable address and write flag until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register offset |
| cfg_wdata_i | input | CW | Register write data |
| cfg_rdata_o | output | CW | Register read data for the offset on `cfg_addr_i` |
| act_req_i | input | NSRC | Activation request lines |
| act_clr_o | output | NSRC | One-cycle clear pulse for the serviced request line |
| mem_req_o | output | 1 | Bus access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_word_o | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_addr_o | output | AW | Bus address |
| mem_wdata_o | output | DW | Bus write data |
| mem_rdata_i | input | DW | Bus read data, valid with ack |
| mem_ack_i | input | 1 | Access complete |
| irq_o | output | 1 | Transfer-end interrupt |

## Verification
The hardest situation to reach is a request line that is still high after the channel has turned itself off. This happens when clearing is disabled, so the request never drops. The bench reaches it by holding the selected request high with clearing off. That drives the blocks back to back until the count runs out, and the line then stays high with the channel idle. The scoreboard flags any bus access after that point.

A similar case covers requests that arrive while only the channel enable is set, or while the select field names no line. Both are followed by a size-register readback, which shows that the live counter was not touched.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  typedef enum logic [1:0] {
    AM_HOLD0 = 2'b00,
    AM_HOLD1 = 2'b01,
    AM_UP    = 2'b10,
    AM_DOWN  = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_e;

  localparam logic [2:0] RG_SRC  = 3'd0;
  localparam logic [2:0] RG_DST  = 3'd1;
  localparam logic [2:0] RG_SIZE = 3'd2;
  localparam logic [2:0] RG_BLKS = 3'd3;
  localparam logic [2:0] RG_CTRL = 3'd4;
  localparam logic [2:0] RG_EN   = 3'd5;

  localparam int SEL_W  = 4;
  localparam int CTRL_W = 12;

  // field order is fixed: word at bit 0 up to irq_en at bit 11
  typedef struct packed {
    logic             irq_en;
    logic             clr_en;
    logic [SEL_W-1:0] sel;
    logic             dst_blk;
    amode_e           dmode;
    amode_e           smode;
    logic             word;
  } ctrl_t;

  // signed step for one unit: -2..+2
  function automatic logic signed [2:0] addr_delta(amode_e m, logic word);
    logic signed [2:0] mag;
    mag = word ? 3'sd2 : 3'sd1;
    case (m)
      AM_UP:   return mag;
      AM_DOWN: return -mag;
      default: return 3'sd0;
    endcase
  endfunction

endpackage

// File: rtl/blkdma_addr.sv
module blkdma_addr
  import blkdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          step_i,
  input  amode_e        mode_i,
  input  logic          word_i,
  input  logic          mark_i,
  input  logic          rewind_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0]     cur_q;
  logic [AW-1:0]     mark_q;
  logic signed [2:0] delta;
  logic [AW-1:0]     delta_ext;
  logic              fixed_mode;

  assign delta      = addr_delta(mode_i, word_i);
  assign delta_ext  = {{(AW-3){delta[2]}}, delta};
  assign fixed_mode = (mode_i == AM_HOLD0) || (mode_i == AM_HOLD1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      mark_q <= '0;
    end else begin
      if (ld_i)          cur_q <= ld_val_i;
      else if (rewind_i) cur_q <= mark_q;
      else if (step_i)   cur_q <= cur_q + delta_ext;
      if (mark_i)        mark_q <= cur_q;
    end
  end

  assign addr_o = cur_q;

  AST_FIXED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && !rewind_i && fixed_mode) |=> $stable(cur_q)); // R3

  AST_REWIND_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rewind_i && !ld_i) |=> (cur_q == $past(mark_q))); // R4

endmodule

// File: rtl/blkdma_count.sv
module blkdma_count #(
  parameter int SZW = 8,
  parameter int BCW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_size_i,
  input  logic [2*SZW-1:0] size_val_i,
  input  logic             ld_blk_i,
  input  logic [BCW-1:0]   blk_val_i,
  input  logic             unit_done_i,
  output logic [SZW-1:0]   live_o,
  output logic [SZW-1:0]   rel_o,
  output logic [BCW-1:0]   blk_o,
  output logic             last_unit_o,
  output logic             last_blk_o
);

  logic [SZW-1:0] live_q;
  logic [SZW-1:0] rel_q;
  logic [BCW-1:0] blk_q;

  assign last_unit_o = (live_q <= SZW'(1));
  assign last_blk_o  = (blk_q <= BCW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      rel_q  <= '0;
    end else if (ld_size_i) begin
      live_q <= size_val_i[SZW-1:0];
      rel_q  <= size_val_i[2*SZW-1:SZW];
    end else if (unit_done_i) begin
      live_q <= last_unit_o ? rel_q : live_q - SZW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         blk_q <= '0;
    else if (ld_blk_i)                   blk_q <= blk_val_i;
    else if (unit_done_i && last_unit_o) blk_q <= blk_q - BCW'(1);
  end

  assign live_o = live_q;
  assign rel_o  = rel_q;
  assign blk_o  = blk_q;

  AST_RELOAD_AFTER_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_done_i && last_unit_o && !ld_size_i) |=> (live_q == rel_q)); // R5

endmodule

// File: rtl/blkdma_fsm.sv
module blkdma_fsm
  import blkdma_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          last_unit_i,
  output logic          idle_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          start_o,
  output logic          unit_done_o,
  output logic [DW-1:0] buf_o
);

  seq_e          st_q, st_d;
  logic [DW-1:0] buf_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE:  if (go_i) st_d = SQ_READ;
      SQ_READ:  if (mem_ack_i) st_d = SQ_WRITE;
      SQ_WRITE: if (mem_ack_i) st_d = last_unit_i ? SQ_IDLE : SQ_READ;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      buf_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SQ_READ && mem_ack_i) buf_q <= mem_rdata_i;
    end
  end

  assign idle_o      = (st_q == SQ_IDLE);
  assign rd_o        = (st_q == SQ_READ);
  assign wr_o        = (st_q == SQ_WRITE);
  assign start_o     = idle_o && go_i;
  assign unit_done_o = wr_o && mem_ack_i;
  assign buf_o       = buf_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o || wr_o) && !mem_ack_i) |=> $stable(st_q)); // R13

endmodule

// File: rtl/blkdma_channel.sv
module blkdma_channel
  import blkdma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int SZW  = 8,
  parameter int BCW  = 16,
  parameter int NSRC = 10,
  parameter int CW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_addr_i,
  input  logic [CW-1:0]   cfg_wdata_i,
  output logic [CW-1:0]   cfg_rdata_o,
  input  logic [NSRC-1:0] act_req_i,
  output logic [NSRC-1:0] act_clr_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            mem_word_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic            irq_o
);

  localparam int NSIDE = 2;

  ctrl_t           ctrl_q;
  logic            chan_en_q, mast_en_q, done_q;
  logic [NSRC-1:0] clr_q;
  logic            run, wr_ok, req_sel, go;
  logic [NSRC-1:0] sel_hot;

  logic            st_idle, st_rd, st_wr, start, unit_done;
  logic [DW-1:0]   buf_data;
  logic [SZW-1:0]  live, rel;
  logic [BCW-1:0]  blk;
  logic            last_unit, last_blk, block_end, xfer_end;

  logic [NSIDE-1:0] side_ld, side_rew;
  amode_e           side_mode [NSIDE];
  logic [AW-1:0]    side_addr [NSIDE];

  assign run   = chan_en_q && mast_en_q;
  assign wr_ok = cfg_we_i && !run;

  always_comb begin
    sel_hot = '0;
    req_sel = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (ctrl_q.sel == SEL_W'(i)) begin
        sel_hot[i] = 1'b1;
        req_sel    = act_req_i[i];
      end
    end
  end

  assign go        = run && req_sel;
  assign block_end = unit_done && last_unit;
  assign xfer_end  = block_end && last_blk;

  blkdma_fsm #(.DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .last_unit_i (last_unit),
    .idle_o      (st_idle),
    .rd_o        (st_rd),
    .wr_o        (st_wr),
    .start_o     (start),
    .unit_done_o (unit_done),
    .buf_o       (buf_data)
  );

  blkdma_count #(.SZW(SZW), .BCW(BCW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_size_i   (wr_ok && cfg_addr_i == RG_SIZE),
    .size_val_i  (cfg_wdata_i[2*SZW-1:0]),
    .ld_blk_i    (wr_ok && cfg_addr_i == RG_BLKS),
    .blk_val_i   (cfg_wdata_i[BCW-1:0]),
    .unit_done_i (unit_done),
    .live_o      (live),
    .rel_o       (rel),
    .blk_o       (blk),
    .last_unit_o (last_unit),
    .last_blk_o  (last_blk)
  );

  // side 0 = source, side 1 = destination
  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    assign side_ld[g]  = wr_ok && (cfg_addr_i == ((g == 0) ? RG_SRC : RG_DST));
    assign side_rew[g] = block_end && (ctrl_q.dst_blk == (g == 1));
    assign side_mode[g] = (g == 0) ? ctrl_q.smode : ctrl_q.dmode;

    blkdma_addr #(.AW(AW)) u_addr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (side_ld[g]),
      .ld_val_i (cfg_wdata_i[AW-1:0]),
      .step_i   (unit_done),
      .mode_i   (side_mode[g]),
      .word_i   (ctrl_q.word),
      .mark_i   (start),
      .rewind_i (side_rew[g]),
      .addr_o   (side_addr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      chan_en_q <= 1'b0;
      mast_en_q <= 1'b0;
      done_q    <= 1'b0;
      clr_q     <= '0;
    end else begin
      if (wr_ok && cfg_addr_i == RG_CTRL) ctrl_q <= ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
      if (cfg_we_i && cfg_addr_i == RG_EN) begin
        chan_en_q <= cfg_wdata_i[0];
        mast_en_q <= cfg_wdata_i[1];
        done_q    <= 1'b0;
      end
      if (xfer_end) begin
        chan_en_q <= 1'b0;
        done_q    <= 1'b1;
      end
      clr_q <= (start && ctrl_q.clr_en) ? sel_hot : '0;
    end
  end

  assign act_clr_o   = clr_q;
  assign irq_o       = done_q && ctrl_q.irq_en;
  assign mem_req_o   = st_rd || st_wr;
  assign mem_we_o    = st_wr;
  assign mem_word_o  = ctrl_q.word;
  assign mem_addr_o  = st_wr ? side_addr[1] : side_addr[0];
  assign mem_wdata_o = ctrl_q.word ? buf_data : {{(DW-8){1'b0}}, buf_data[7:0]};

  always_comb begin
    case (cfg_addr_i)
      RG_SRC:  cfg_rdata_o = CW'(side_addr[0]);
      RG_DST:  cfg_rdata_o = CW'(side_addr[1]);
      RG_SIZE: cfg_rdata_o = CW'({rel, live});
      RG_BLKS: cfg_rdata_o = CW'(blk);
      RG_CTRL: cfg_rdata_o = CW'(ctrl_q);
      RG_EN:   cfg_rdata_o = CW'({done_q, mast_en_q, chan_en_q});
      default: cfg_rdata_o = '0;
    endcase
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_clr_o)); // R9

  AST_END_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end |=> (!chan_en_q && done_q)); // R6

  AST_IDLE_NO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_idle && !run) |=> !mem_req_o); // R12

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R13

  AST_CTRL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && run && cfg_addr_i == RG_CTRL) |=> $stable(ctrl_q)); // R11

endmodule

// File: tb/sim_blkdma_channel.sv
module sim_blkdma_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [9:0]  act_req = '0;
  logic [9:0]  act_clr;
  logic        mem_req, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int clr_pulses = 0;

  typedef struct {
    logic [15:0] s;
    logic [15:0] d;
    logic [15:0] v;
    logic        w;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  blkdma_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .act_req_i(act_req),
    .act_clr_o(act_clr), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_word_o(mem_word), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .irq_o(irq)
  );

  function automatic logic [15:0] mdat(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] nx(input logic [15:0] a, input logic [1:0] m, input logic w);
    logic [15:0] st;
    st = w ? 16'd2 : 16'd1;
    if (m == 2'b10) return a + st;
    if (m == 2'b11) return a - st;
    return a;
  endfunction

  function automatic logic [15:0] ctl(input logic ie, input logic ce, input logic [3:0] sel,
                                      input logic db, input logic [1:0] dm, input logic [1:0] sm,
                                      input logic w);
    return {4'b0, ie, ce, sel, db, dm, sm, w};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor + memory responder, both off the active edge
  always @(negedge clk) begin
    clr_pulses += $countones(act_clr);
    if (rst_n && mem_req && mem_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected access", mem_addr, 16'hxxxx);
      end else if (!mem_we) begin
        chk(mem_addr == exp_q[0].s, "R3 read address", mem_addr, exp_q[0].s);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(mem_addr == it.d, "R4 write address", mem_addr, it.d);
        chk(mem_wdata == it.v, "R2 write data", mem_wdata, it.v);
        chk(mem_word == it.w, "R2 unit size", {15'b0, mem_word}, {15'b0, it.w});
      end
    end
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      mem_rdata = mdat(mem_addr);
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [15:0] e, input string tag);
    logic [15:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic push_run(input logic [15:0] s0, input logic [15:0] d0, input logic [1:0] sm,
                          input logic [1:0] dm, input logic w, input logic db, input int sz,
                          input int nb, output logic [15:0] fs, output logic [15:0] fd);
    logic [15:0] s, d, bs, bd;
    item_t it;
    s = s0; d = d0;
    for (int b = 0; b < nb; b++) begin
      bs = s; bd = d;
      for (int u = 0; u < sz; u++) begin
        it.s = s; it.d = d; it.w = w;
        it.v = w ? mdat(s) : {8'h00, mdat(s)[7:0]};
        exp_q.push_back(it);
        s = nx(s, sm, w);
        d = nx(d, dm, w);
      end
      if (db) d = bd; else s = bs;
    end
    fs = s; fd = d;
  endtask

  task automatic wait_clr(input int idx);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (act_clr[idx]) begin
        act_req[idx] = 1'b0;
        return;
      end
    end
    chk(1'b0, "R9 clear pulse missing", act_clr, 16'h0);
    act_req[idx] = 1'b0;
  endtask

  task automatic wait_idle();
    int lows;
    lows = 0;
    while (lows < 4) begin
      @(negedge clk);
      lows = mem_req ? 0 : lows + 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] fs, fd, cv;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) rchk(3'(a), 16'h0, "R1 register reset");
    chk(irq == 1'b0 && mem_req == 1'b0 && act_clr == '0, "R1 outputs at reset",
        {irq, mem_req, 14'b0}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // T2: bytes, both increment, destination is block area, size 4, 3 blocks
    wr(3'd0, 16'h0100); wr(3'd1, 16'h0200); wr(3'd2, 16'h0404); wr(3'd3, 16'd3);
    wr(3'd4, ctl(1'b1, 1'b1, 4'd2, 1'b1, 2'b10, 2'b10, 1'b0));
    clr_pulses = 0;
    push_run(16'h0100, 16'h0200, 2'b10, 2'b10, 1'b0, 1'b1, 4, 3, fs, fd);
    wr(3'd5, 16'h0003);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk); act_req[2] = 1'b1;
      wait_clr(2);
      wait_idle();
    end
    chk(exp_q.size() == 0, "R2 all units moved", 16'(exp_q.size()), 16'h0);
    rchk(3'd0, fs, "R4 source advanced");
    rchk(3'd1, fd, "R4 destination rewound");
    rchk(3'd2, 16'h0404, "R5 size reloaded");
    rchk(3'd3, 16'h0000, "R6 blocks exhausted");
    rchk(3'd5, 16'h0006, "R6 channel off and done");
    chk(irq == 1'b1, "R10 irq raised", {15'b0, irq}, 16'h1);
    chk(clr_pulses == 3, "R9 one clear per block", 16'(clr_pulses), 16'd3);
    // R12: request after end does nothing
    @(negedge clk); act_req[2] = 1'b1;
    repeat (20) @(negedge clk);
    act_req[2] = 1'b0;
    chk(clr_pulses == 3, "R12 no service after end", 16'(clr_pulses), 16'd3);
    rchk(3'd0, fs, "R12 source untouched after end");
    wr(3'd5, 16'h0000);
    chk(irq == 1'b0, "R10 done cleared by enable write", {15'b0, irq}, 16'h0);

    // T3: words, source decrement and block area, destination fixed, held request, no clear, no irq
    wr(3'd0, 16'h0400); wr(3'd1, 16'h0800); wr(3'd2, 16'h0303); wr(3'd3, 16'd2);
    cv = ctl(1'b0, 1'b0, 4'd7, 1'b0, 2'b00, 2'b11, 1'b1);
    wr(3'd4, cv);
    wr(3'd5, 16'h0003);
    wr(3'd4, 16'h0FFF);
    rchk(3'd4, cv, "R11 control locked while enabled");
    wr(3'd0, 16'h1234);
    rchk(3'd0, 16'h0400, "R11 source locked while enabled");
    clr_pulses = 0;
    push_run(16'h0400, 16'h0800, 2'b11, 2'b00, 1'b1, 1'b0, 3, 2, fs, fd);
    @(negedge clk); act_req[7] = 1'b1;
    wait_idle();
    repeat (20) @(negedge clk);
    act_req[7] = 1'b0;
    chk(exp_q.size() == 0, "R2 held request ran all blocks", 16'(exp_q.size()), 16'h0);
    rchk(3'd0, fs, "R4 source rewound");
    rchk(3'd1, fd, "R3 destination fixed");
    rchk(3'd5, 16'h0006, "R6 held request ended");
    chk(irq == 1'b0, "R10 irq masked", {15'b0, irq}, 16'h0);
    chk(clr_pulses == 0, "R9 no clear when disabled", 16'(clr_pulses), 16'h0);

    // T4: no-line select, channel-only enable, then word run with destination decrement
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'h0300); wr(3'd1, 16'h0900); wr(3'd2, 16'h0202); wr(3'd3, 16'd1);
    wr(3'd4, ctl(1'b1, 1'b1, 4'd12, 1'b1, 2'b11, 2'b10, 1'b1));
    wr(3'd5, 16'h0003);
    @(negedge clk); act_req = '1;
    repeat (20) @(negedge clk);
    act_req = '0;
    rchk(3'd2, 16'h0202, "R8 out-of-range select ignored");
    wr(3'd5, 16'h0000);
    wr(3'd4, ctl(1'b1, 1'b1, 4'd5, 1'b1, 2'b11, 2'b10, 1'b1));
    wr(3'd5, 16'h0001);
    @(negedge clk); act_req[5] = 1'b1; act_req[3] = 1'b1;
    repeat (20) @(negedge clk);
    rchk(3'd2, 16'h0202, "R7 master off blocks start");
    act_req[3] = 1'b0;
    clr_pulses = 0;
    push_run(16'h0300, 16'h0900, 2'b10, 2'b11, 1'b1, 1'b1, 2, 1, fs, fd);
    wr(3'd5, 16'h0003);
    wait_clr(5);
    wait_idle();
    chk(exp_q.size() == 0, "R8 selected line served", 16'(exp_q.size()), 16'h0);
    rchk(3'd0, fs, "R3 word increment");
    rchk(3'd1, fd, "R4 decrementing block area rewound");
    rchk(3'd5, 16'h0006, "R6 single block ends");
    chk(irq == 1'b1, "R10 irq after end", {15'b0, irq}, 16'h1);
    chk(clr_pulses == 1, "R9 clear for line 5", 16'(clr_pulses), 16'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule